// File: doc/BRIEF.md
# Configurable Asynchronous Character Transmitter

The block turns characters written by a host into asynchronous serial frames on one output line. Each frame is a low start bit, then the data bits least significant first, then an optional parity bit, then a high stop period. The character length, parity mode and stop length are set by static configuration inputs. Bit timing comes from an external tick that pulses once per clock at sixteen times the bit rate. The block does not generate this tick.

A one-character holding register sits in front of the shifting engine. The host can therefore queue the next character while the current one is still being sent. Back-to-back characters go out with no idle gap between frames. The configuration is captured when a character moves from the holding register into the engine, so the host may change the settings while a frame is on the line. Two status outputs are provided: one shows that the holding register can take a character, and one shows that the whole transmitter has drained.

Top module: `async_char_tx`

## Requirements
- R1: The line rests at 1 while nothing is being sent. A frame starts with a 0 start bit and ends with stop time at 1.
- R2: Data bits go out least significant first. The number of data bits is 5 + `len_sel` (codes 0..3 give 5..8 bits). Host bits above the chosen length are ignored.
- R3: `par_sel` picks the parity bit. Code 2'b01 adds an odd parity bit and code 2'b10 adds an even parity bit, either one sent right after the last data bit. Codes 2'b00 and 2'b11 add no parity bit.
- R4: Each bit lasts 16 ticks. `stop_sel` sets the stop time: code 0 gives 16 ticks, code 1 gives 24 ticks, and codes 2 and 3 give 32 ticks.
- R5: A character waiting in the holding register starts on the line one clock after the previous frame's last stop tick, with no idle bit time between the frames.
- R6: `hold_empty` is 1 when the holding register is free. It drops in the clock after an accepted write.
- R7: `tx_idle` is 1 only when the holding register is free and no frame is being sent. While it is 1, `hold_empty` is also 1.
- R8: The settings are captured when a character enters the engine. Changing the settings during a frame does not alter that frame.
- R9: A write while the holding register is full is dropped. It produces no frame and does not replace the queued character.
- R10: After reset, `txd` is 1, `hold_empty` is 1 and `tx_idle` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-clock pulse at 16x the bit rate |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host character |
| len_sel | input | 2 | Character length code (5 + code bits) |
| par_sel | input | 2 | Parity code: 01 odd, 10 even, 00/11 none |
| stop_sel | input | 2 | Stop length code: 0 one bit, 1 one and a half, 2/3 two |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can take a character |
| tx_idle | output | 1 | Holding register and engine both empty |

## Verification
The hardest cases to reach from the ports are a write that lands on a full holding register in the same clock that the engine takes the queued character, and a settings change while a frame is mid-flight. To reach the first, the stimulus sometimes issues a second write with altered data in the clock right after an accepted one. To reach the second, it changes the settings whenever the holding register frees up, and it queues characters back to back so that new settings are applied while the previous frame is still shifting. Frame length is measured in ticks from one start edge to the next, or to the idle flag, so that stop lengths and gap-free chaining are both checked exactly.

// File: rtl/tx_cfg_pkg.sv
// Package: shared constants and types for the asynchronous character transmitter.
// Assumes an 8-bit host byte and a 16x oversampling tick.
package tx_cfg_pkg;
    localparam int TX_DATA_W   = 8;                        // widest character
    localparam int TX_OSR      = 16;                       // ticks per bit
    localparam int TX_MIN_BITS = TX_DATA_W - 3;            // shortest character
    localparam int TX_CNT_W    = $clog2(2 * TX_OSR);       // tick counter width
    localparam int TX_IDX_W    = $clog2(TX_DATA_W);        // data bit index width

    // Decoded frame settings captured with each character
    typedef struct packed {
        logic [TX_IDX_W-1:0] nbits_m1;   // data bit count minus one
        logic                par_en;     // parity bit present
        logic                par_odd;    // odd (1) or even (0) parity
        logic [TX_CNT_W-1:0] stop_last;  // last tick index of the stop time
    } frame_cfg_t;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_START,
        TS_DATA,
        TS_PAR,
        TS_STOP
    } tx_state_t;
endpackage

// File: rtl/tx_cfg_decode.sv
// Module: tx_cfg_decode
// Turns the raw configuration codes into a decoded frame setting.
// Purely combinational; assumes the codes are static while sampled.
module tx_cfg_decode
    import tx_cfg_pkg::*;
#(
    parameter int OSR = TX_OSR
) (
    input  logic [1:0]  len_sel,
    input  logic [1:0]  par_sel,
    input  logic [1:0]  stop_sel,
    output frame_cfg_t  cfg
);
    localparam int STOP1_LAST  = OSR - 1;
    localparam int STOP15_LAST = OSR + (OSR / 2) - 1;
    localparam int STOP2_LAST  = 2 * OSR - 1;

    // Decode length, parity and stop codes into the frame setting
    always_comb begin
        cfg.nbits_m1 = TX_IDX_W'(TX_MIN_BITS - 1) + TX_IDX_W'(len_sel);
        cfg.par_en   = (par_sel == 2'b01) || (par_sel == 2'b10);
        cfg.par_odd  = (par_sel == 2'b01);
        case (stop_sel)
            2'd0:    cfg.stop_last = TX_CNT_W'(STOP1_LAST);
            2'd1:    cfg.stop_last = TX_CNT_W'(STOP15_LAST);
            default: cfg.stop_last = TX_CNT_W'(STOP2_LAST);
        endcase
    end
endmodule

// File: rtl/tx_hold_buf.sv
// Module: tx_hold_buf
// One-character holding register between the host and the frame engine.
// Assumes a write is dropped while full; take clears it in the same clock.
module tx_hold_buf #(
    parameter int DATA_W = tx_cfg_pkg::TX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data_q
);
    // Capture a host character when free, release it when the engine takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            data_q <= '0;
        end else if (wr_en && !full) begin
            full   <= 1'b1;
            data_q <= wr_data;
        end else if (take) begin
            full   <= 1'b0;
        end
    end

    // R9
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> $stable(data_q));

    // R6
    accept_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full) |=> (full && data_q == $past(wr_data)));
endmodule

// File: rtl/tx_frame_engine.sv
// Module: tx_frame_engine
// Shifts one character out as start, data (LSB first), optional parity and stop.
// Assumes load only arrives while idle; every state step waits for tick.
module tx_frame_engine
    import tx_cfg_pkg::*;
#(
    parameter int DATA_W = TX_DATA_W,
    parameter int OSR    = TX_OSR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  frame_cfg_t        load_cfg,
    output logic              busy,
    output logic              txd
);
    localparam logic [TX_CNT_W-1:0] BIT_LAST = TX_CNT_W'(OSR - 1);

    tx_state_t           state;
    frame_cfg_t          cfg_q;
    logic [DATA_W-1:0]   sh;
    logic [DATA_W-1:0]   mask;
    logic [TX_CNT_W-1:0] tick_cnt;
    logic [TX_IDX_W-1:0] bit_idx;
    logic                par_bit;
    logic                txd_q;
    logic                bit_end;

    // One mask bit per data position: keep bits within the chosen length
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (TX_IDX_W'(g) <= load_cfg.nbits_m1);
    end

    // Detect the last tick of the current bit or of the stop time
    always_comb begin
        if (state == TS_STOP) bit_end = (tick_cnt == cfg_q.stop_last);
        else                  bit_end = (tick_cnt == BIT_LAST);
    end

    // Frame sequencer: load, then step through the bit slots on ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= TS_IDLE;
            cfg_q    <= '0;
            sh       <= '0;
            tick_cnt <= '0;
            bit_idx  <= '0;
            par_bit  <= 1'b0;
            txd_q    <= 1'b1;
        end else if (load) begin
            state    <= TS_START;
            cfg_q    <= load_cfg;
            sh       <= load_data & mask;
            par_bit  <= (^(load_data & mask)) ^ load_cfg.par_odd;
            tick_cnt <= '0;
            bit_idx  <= '0;
            txd_q    <= 1'b0;
        end else if (tick && state != TS_IDLE) begin
            if (!bit_end) begin
                tick_cnt <= tick_cnt + 1'b1;
            end else begin
                tick_cnt <= '0;
                case (state)
                    TS_START: begin
                        state <= TS_DATA;
                        txd_q <= sh[0];
                        sh    <= sh >> 1;
                    end
                    TS_DATA: begin
                        if (bit_idx == cfg_q.nbits_m1) begin
                            if (cfg_q.par_en) begin
                                state <= TS_PAR;
                                txd_q <= par_bit;
                            end else begin
                                state <= TS_STOP;
                                txd_q <= 1'b1;
                            end
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            txd_q   <= sh[0];
                            sh      <= sh >> 1;
                        end
                    end
                    TS_PAR: begin
                        state <= TS_STOP;
                        txd_q <= 1'b1;
                    end
                    default: begin
                        state <= TS_IDLE;
                        txd_q <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign busy = (state != TS_IDLE);
    assign txd  = txd_q;

    // R1
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!txd && busy));

    // R1
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_STOP) |-> txd);

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> $stable(cfg_q));

    // R4
    stop_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_STOP) |-> (tick_cnt <= cfg_q.stop_last));
endmodule

// File: rtl/async_char_tx.sv
// Module: async_char_tx (top)
// Double-buffered asynchronous character transmitter with runtime framing.
// Assumes tick16 is a single-clock pulse at 16x the bit rate.
module async_char_tx
    import tx_cfg_pkg::*;
#(
    parameter int DATA_W = TX_DATA_W,
    parameter int OSR    = TX_OSR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        len_sel,
    input  logic [1:0]        par_sel,
    input  logic [1:0]        stop_sel,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_idle
);
    frame_cfg_t        cfg_now;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              eng_busy;
    logic              eng_load;

    tx_cfg_decode #(.OSR(OSR)) u_dec (
        .len_sel  (len_sel),
        .par_sel  (par_sel),
        .stop_sel (stop_sel),
        .cfg      (cfg_now)
    );

    tx_hold_buf #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (eng_load),
        .full    (hold_full),
        .data_q  (hold_data)
    );

    tx_frame_engine #(.DATA_W(DATA_W), .OSR(OSR)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .load      (eng_load),
        .load_data (hold_data),
        .load_cfg  (cfg_now),
        .busy      (eng_busy),
        .txd       (txd)
    );

    // Move a queued character into the engine as soon as it is free
    assign eng_load   = hold_full && !eng_busy;
    assign hold_empty = !hold_full;
    assign tx_idle    = !hold_full && !eng_busy;

    // R7
    idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> (hold_empty && txd));
endmodule

// File: tb/sim_async_char_tx.sv
// Bench: random and directed characters, frames decoded from txd by tick count.
module sim_async_char_tx;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] len_sel = '0;
    logic [1:0] par_sel = '0;
    logic [1:0] stop_sel = '0;
    logic       txd, hold_empty, tx_idle;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    logic [7:0] q_d[$];
    logic [1:0] q_len[$];
    logic [1:0] q_par[$];
    logic [1:0] q_stop[$];

    int unsigned tick_total = 0;
    logic        tick_last = 1'b0;

    async_char_tx u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en),
        .wr_data(wr_data), .len_sel(len_sel), .par_sel(par_sel),
        .stop_sel(stop_sel), .txd(txd), .hold_empty(hold_empty),
        .tx_idle(tx_idle)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Count the ticks the design consumes
    always @(posedge clk) begin
        tick_last <= tick16;
        if (tick16) tick_total <= tick_total + 1;
    end

    // Tick every 4 clocks
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic int nbits_of(input logic [1:0] len);
        return 5 + int'(len);
    endfunction

    function automatic bit par_on(input logic [1:0] par);
        return (par == 2'b01) || (par == 2'b10);
    endfunction

    function automatic int stop_ticks(input logic [1:0] stop);
        if (stop == 2'd0) return 16;
        if (stop == 2'd1) return 24;
        return 32;
    endfunction

    // Expected level of bit slot i (0 = start)
    function automatic logic frame_bit(input logic [7:0] d, input logic [1:0] len,
                                       input logic [1:0] par, input int i);
        int n;
        logic p;
        n = nbits_of(len);
        if (i == 0) return 1'b0;
        if (i <= n) return d[i-1];
        p = 1'b0;
        for (int k = 0; k < n; k++) p = p ^ d[k];
        if (par == 2'b01) p = ~p;
        return p;
    endfunction

    // Wait until count ticks have been consumed since t0
    task automatic wait_ticks(input int unsigned t0, input int count);
        while (tick_total - t0 < count) @(negedge clk);
    endtask

    // Frame monitor: decode every frame against the queue
    initial begin
        bit at_start;
        at_start = 0;
        @(posedge rst_n);
        forever begin
            int unsigned t0, t_end;
            logic [7:0] d;
            logic [1:0] ln, pr, st;
            int nb, stt;
            bit by_fall;
            if (!at_start) begin
                do @(negedge clk); while (txd !== 1'b0);
            end
            t0 = tick_total - int'(tick_last);
            if (q_d.size() == 0) begin
                check(0, "R9 unexpected frame", 1, 0);
                do @(negedge clk); while (!(tx_idle === 1'b1));
                at_start = 0;
                continue;
            end
            d = q_d.pop_front(); ln = q_len.pop_front();
            pr = q_par.pop_front(); st = q_stop.pop_front();
            nb = 1 + nbits_of(ln) + int'(par_on(pr));
            stt = stop_ticks(st);
            for (int i = 0; i < nb; i++) begin
                logic e;
                e = frame_bit(d, ln, pr, i);
                wait_ticks(t0, 8 + 16 * i);
                if (i == 0) begin
                    check(txd === 1'b0, "R1 start bit", int'(txd), 0);
                    check(tx_idle === 1'b0, "R7 busy not idle", int'(tx_idle), 0);
                end else if (i <= nbits_of(ln)) begin
                    check(txd === e, "R2 data bit", int'(txd), int'(e));
                end else begin
                    check(txd === e, "R3 parity bit", int'(txd), int'(e));
                end
            end
            wait_ticks(t0, 16 * nb + 8);
            check(txd === 1'b1, "R1 stop level", int'(txd), 1);
            wait_ticks(t0, 16 * nb + stt - 1);
            check(txd === 1'b1, "R4 stop end level", int'(txd), 1);
            do @(negedge clk); while (!(txd === 1'b0 || tx_idle === 1'b1));
            by_fall = (txd === 1'b0);
            if (by_fall) t_end = tick_total - int'(tick_last);
            else         t_end = tick_total;
            check(int'(t_end - t0) == 16 * nb + stt,
                  by_fall ? "R5 back-to-back frame length" : "R4 frame length",
                  int'(t_end - t0), 16 * nb + stt);
            at_start = by_fall;
        end
    end

    // Queue one character, optionally followed by a write that must be dropped
    task automatic send(input logic [7:0] d, input logic [1:0] ln, input logic [1:0] pr,
                        input logic [1:0] st, input bit junk);
        do @(negedge clk); while (hold_empty !== 1'b1);
        len_sel = ln; par_sel = pr; stop_sel = st;
        wr_en = 1'b1; wr_data = d;
        q_d.push_back(d); q_len.push_back(ln); q_par.push_back(pr); q_stop.push_back(st);
        @(negedge clk);
        wr_en = 1'b0;
        check(hold_empty === 1'b0, "R6 full after write", int'(hold_empty), 0);
        if (junk) begin
            wr_en = 1'b1; wr_data = ~d;
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (tx_idle !== 1'b1);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R5 watchdog expired act=%0d exp=%0d", 1, 0);
        finish_run();
    end

    // Main sequence
    initial begin
        process::self().srandom(32'd2024);
        repeat (5) @(negedge clk);
        check(txd === 1'b1, "R10 reset txd", int'(txd), 1);
        check(hold_empty === 1'b1, "R10 reset hold_empty", int'(hold_empty), 1);
        check(tx_idle === 1'b1, "R10 reset tx_idle", int'(tx_idle), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(txd === 1'b1, "R1 idle line high", int'(txd), 1);

        // Directed: every length, parity and stop code; upper bits set (R2)
        for (int l = 0; l < 4; l++) begin
            for (int p = 0; p < 4; p++) begin
                for (int s = 0; s < 3; s++) begin
                    send(8'hE0 | 8'($urandom_range(0, 31)), 2'(l), 2'(p), 2'(s), 0);
                    if (s == 2) wait_idle();
                end
            end
        end
        // Directed: dropped write on a full holding register (R9), settings change mid-frame (R8)
        send(8'h55, 2'd3, 2'b10, 2'd0, 1);
        send(8'hA3, 2'd0, 2'b01, 2'd1, 1);
        send(8'h0F, 2'd2, 2'b00, 2'd3, 0);
        wait_idle();

        // Random mix
        for (int k = 0; k < 30; k++) begin
            send(8'($urandom), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                 2'($urandom_range(0, 3)), bit'($urandom_range(0, 1)));
            if ($urandom_range(0, 3) == 0) wait_idle();
        end

        wait_idle();
        repeat (200) @(negedge clk);
        check(q_d.size() == 0, "R9 no missing or extra frames", q_d.size(), 0);
        check(tx_idle === 1'b1, "R7 idle at end", int'(tx_idle), 1);
        check(hold_empty === 1'b1, "R6 empty at end", int'(hold_empty), 1);
        check(txd === 1'b1, "R1 line high at end", int'(txd), 1);
        finish_run();
    end
endmodule